// File: doc/BRIEF.md
# Restart Interrupt Controller

This block sits in front of a small processor core and decides when one of a few restart interrupt sources may break into program flow. A global interrupt enable gates every source. Each source also has its own mask bit. The core sets the global enable with one command pulse and clears it with another. It loads the per-source masks through a mask write and reads a combined status view of the enable, the masks and the pending requests.

When the global enable is on and at least one pending source is unmasked, the block raises a request and shows the restart address of the winning source. Restart addresses sit on fixed multiples of eight. When the core acknowledges the request, the block clears the global enable. If the serviced source is the edge-triggered one, the block also clears that source's latched request. Pushing the return address and jumping to the vector are left to the core.

Top module: `rst_intc`

## Requirements
- R1: After reset the global enable is 0, every mask bit is 1, every pending bit is 0 and `irq_req` is 0.
- R2: A pulse on `en_cmd` sets the global enable and a pulse on `dis_cmd` clears it. When both arrive in the same cycle, the disable wins.
- R3: In a mask write (`mask_wr`=1), bit 3 of `mask_wdata` is the load-enable. When bit 3 is 1, bits 2:0 replace the masks of sources 2, 1 and 0 on the next clock edge (1 = masked).
- R4: A mask write with bit 3 equal to 0 leaves all three masks unchanged.
- R5: `rd_view` places the masks in bits 2:0, the global enable in bit 3 and the pending bits of sources 0, 1 and 2 in bits 6:4.
- R6: Sources 0 and 1 are level-sensitive. Their pending bit follows the input, one clock later.
- R7: Source 2 is edge-triggered. A rising input sets its pending bit, and the bit stays set after the input falls. It clears only when source 2 is serviced, or on a mask write with bit 4 of `mask_wdata` equal to 1.
- R8: `irq_req` is 1 exactly when the global enable is 1 and some source is both pending and unmasked.
- R9: When several sources are eligible, the highest-numbered one wins.
- R10: The vector for source i is (5+i)*8. Sources 0, 1 and 2 therefore map to 0x28, 0x30 and 0x38.
- R11: An acknowledge while `irq_req` is 1 clears the global enable. It clears the pending bit of source 2 if source 2 was the winner. The pending bits of the level sources stay as they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_cmd | input | 1 | Enable-interrupts command pulse |
| dis_cmd | input | 1 | Disable-interrupts command pulse |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | N_SRC+2 | Masks, load-enable, edge-pending clear |
| src_in | input | N_SRC | Raw restart interrupt inputs |
| irq_ack | input | 1 | Core acknowledge of the current request |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | ADDR_W | Restart address of the winning source |
| rd_view | output | 2*N_SRC+1 | Status view: pending, enable, masks |

## Verification
The bench builds the block with its defaults: three sources, source 2 edge-triggered, first slot 5, stride 8 and 16-bit addresses. With these values all three vectors, 0x28, 0x30 and 0x38, can be reached. Every two-way and three-way priority contest can occur. The one edge source can be driven against the two level sources, so the bench shows that a serviced level request survives an acknowledge while a serviced edge request is dropped. A cycle-level model in the bench predicts the status view, the request and the vector after each stimulus cycle.

// File: rtl/rst_intc_pkg.sv
package rst_intc_pkg;
   // Restart address of a source: (first slot + index) * stride
   function automatic logic [31:0] slot_addr(input int base, input int idx, input int stride);
      return 32'((base + idx) * stride);
   endfunction
endpackage

// File: rtl/rst_intc_src.sv
module rst_intc_src #(
   parameter bit EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic clr,
   output logic pend
);
   generate
      if (EDGE) begin : g_edge
         logic prev_q, pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               prev_q <= raw;
               if (raw && !prev_q) pend_q <= 1'b1;
               else if (clr)       pend_q <= 1'b0;
            end
         end
         assign pend = pend_q;
      end else begin : g_level
         logic lvl_q;
         logic clr_unused;
         assign clr_unused = clr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= raw;
         end
         assign pend = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/rst_intc_pick.sv
module rst_intc_pick #(
   parameter int N_SRC = 3,
   localparam int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] elig,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (elig[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/rst_intc_regs.sv
module rst_intc_regs #(
   parameter int N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_cmd,
   input  logic             dis_cmd,
   input  logic             take,
   input  logic             ld_mask,
   input  logic [N_SRC-1:0] new_mask,
   output logic             gie,
   output logic [N_SRC-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie  <= 1'b0;
         mask <= '1;
      end else begin
         if (take || dis_cmd) gie <= 1'b0;
         else if (en_cmd)     gie <= 1'b1;
         if (ld_mask) mask <= new_mask;
      end
   end
endmodule

// File: rtl/rst_intc.sv
module rst_intc #(
   parameter int N_SRC     = 3,
   parameter int EDGE_SRC  = 2,
   parameter int SLOT_BASE = 5,
   parameter int VEC_STRIDE = 8,
   parameter int ADDR_W    = 16,
   localparam int IDX_W    = $clog2(N_SRC),
   localparam int WD_W     = N_SRC + 2,
   localparam int VIEW_W   = 2 * N_SRC + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_cmd,
   input  logic              dis_cmd,
   input  logic              mask_wr,
   input  logic [WD_W-1:0]   mask_wdata,
   input  logic [N_SRC-1:0]  src_in,
   input  logic              irq_ack,
   output logic              irq_req,
   output logic [ADDR_W-1:0] irq_vec,
   output logic [VIEW_W-1:0] rd_view
);
   generate
      if (N_SRC < 2 || N_SRC > 8) begin : g_bad_n
         $error("rst_intc: N_SRC must be 2..8");
      end
      if (EDGE_SRC < 0 || EDGE_SRC >= N_SRC) begin : g_bad_edge
         $error("rst_intc: EDGE_SRC out of range");
      end
      if (VEC_STRIDE <= 0 || (VEC_STRIDE % 8) != 0) begin : g_bad_stride
         $error("rst_intc: VEC_STRIDE must be a positive multiple of 8");
      end
      if (ADDR_W < 31 && (SLOT_BASE + N_SRC) * VEC_STRIDE > (1 << ADDR_W)) begin : g_bad_addr
         $error("rst_intc: vectors do not fit ADDR_W");
      end
   endgenerate

   logic             gie;
   logic [N_SRC-1:0] mask;
   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] elig;
   logic             any;
   logic [IDX_W-1:0] win_idx;
   logic             take;
   logic             clr_edge;
   logic             ld_mask;

   assign ld_mask  = mask_wr && mask_wdata[N_SRC];
   assign take     = irq_ack && irq_req;
   assign clr_edge = (take && (win_idx == IDX_W'(EDGE_SRC))) ||
                     (mask_wr && mask_wdata[N_SRC+1]);

   rst_intc_regs #(.N_SRC(N_SRC)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_cmd   (en_cmd),
      .dis_cmd  (dis_cmd),
      .take     (take),
      .ld_mask  (ld_mask),
      .new_mask (mask_wdata[N_SRC-1:0]),
      .gie      (gie),
      .mask     (mask)
   );

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         rst_intc_src #(.EDGE(i == EDGE_SRC)) u_src (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (src_in[i]),
            .clr   (clr_edge),
            .pend  (pend[i])
         );
      end
   endgenerate

   assign elig = pend & ~mask;

   rst_intc_pick #(.N_SRC(N_SRC)) u_pick (
      .elig (elig),
      .any  (any),
      .idx  (win_idx)
   );

   assign irq_req = gie && any;
   assign irq_vec = ADDR_W'(rst_intc_pkg::slot_addr(SLOT_BASE, int'(win_idx), VEC_STRIDE));
   assign rd_view = {pend, gie, mask};
endmodule

// File: rtl/rst_intc_chk.sv
module rst_intc_chk #(
   parameter int N_SRC    = 3,
   parameter int EDGE_SRC = 2,
   parameter int ADDR_W   = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 en_cmd,
   input logic                 dis_cmd,
   input logic                 mask_wr,
   input logic [N_SRC+1:0]     mask_wdata,
   input logic                 irq_ack,
   input logic                 irq_req,
   input logic [ADDR_W-1:0]    irq_vec,
   input logic [2*N_SRC:0]     rd_view
);
   a_r2_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (en_cmd && !dis_cmd && !(irq_ack && irq_req)) |=> rd_view[N_SRC]);

   a_r2_disable: assert property (@(posedge clk) disable iff (!rst_n)
      dis_cmd |=> !rd_view[N_SRC]);

   a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && mask_wdata[N_SRC]) |=> (rd_view[N_SRC-1:0] == $past(mask_wdata[N_SRC-1:0])));

   a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && !mask_wdata[N_SRC]) |=> $stable(rd_view[N_SRC-1:0]));

   a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_view[N_SRC+1+EDGE_SRC] && !(irq_ack && irq_req) && !(mask_wr && mask_wdata[N_SRC+1]))
      |=> rd_view[N_SRC+1+EDGE_SRC]);

   a_r8_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> rd_view[N_SRC]);

   a_r10_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec[2:0] == 3'b000));

   a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !irq_req);
endmodule

bind rst_intc rst_intc_chk #(.N_SRC(N_SRC), .EDGE_SRC(EDGE_SRC), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_cmd     (en_cmd),
   .dis_cmd    (dis_cmd),
   .mask_wr    (mask_wr),
   .mask_wdata (mask_wdata),
   .irq_ack    (irq_ack),
   .irq_req    (irq_req),
   .irq_vec    (irq_vec),
   .rd_view    (rd_view)
);

// File: tb/sim_rst_intc.sv
module sim_rst_intc;
   localparam int N = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_cmd = 1'b0, dis_cmd = 1'b0, mask_wr = 1'b0, irq_ack = 1'b0;
   logic [4:0]  mask_wdata = '0;
   logic [2:0]  src_in = '0;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic [6:0]  rd_view;

   always #2 clk = ~clk;   // 250 MHz

   rst_intc u0 (
      .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
      .mask_wr(mask_wr), .mask_wdata(mask_wdata), .src_in(src_in),
      .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec), .rd_view(rd_view)
   );

   typedef struct {
      int          due;
      logic [6:0]  view;
      logic        req;
      logic [15:0] vec;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 0;

   // reference model state
   logic       m_gie = 1'b0;
   logic [2:0] m_mask = 3'b111;
   logic [2:0] m_pend = 3'b000;
   logic       m_prev = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare against expectations due this cycle
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         e = q.pop_front();
         n_run++;
         if (rd_view !== e.view || irq_req !== e.req || (e.req && irq_vec !== e.vec)) begin
            n_fail++;
            $display("FAIL %s: view=%h req=%b vec=%h expected view=%h req=%b vec=%h",
                     e.tag, rd_view, irq_req, irq_vec, e.view, e.req, e.vec);
         end
      end
   end

   function automatic int top_idx(input logic [2:0] v);
      int r = -1;
      for (int i = 0; i < N; i++) if (v[i]) r = i;
      return r;
   endfunction

   // driver: apply one cycle of stimulus, predict result, push expectation
   task automatic step(input logic en, input logic dis, input logic wr,
                       input logic [4:0] wd, input logic [2:0] src,
                       input logic ack, input string tag);
      logic [2:0] elig;
      logic       take, clr;
      int         win;
      exp_t       e;
      en_cmd = en; dis_cmd = dis; mask_wr = wr; mask_wdata = wd;
      src_in = src; irq_ack = ack;
      elig = m_pend & ~m_mask;
      win  = top_idx(elig);
      take = ack && m_gie && (win >= 0);
      clr  = (take && win == 2) || (wr && wd[4]);
      m_pend[0] = src[0];
      m_pend[1] = src[1];
      if (src[2] && !m_prev) m_pend[2] = 1'b1;
      else if (clr)          m_pend[2] = 1'b0;
      m_prev = src[2];
      if (take || dis) m_gie = 1'b0;
      else if (en)     m_gie = 1'b1;
      if (wr && wd[3]) m_mask = wd[2:0];
      elig = m_pend & ~m_mask;
      win  = top_idx(elig);
      e.due  = cyc + 1;
      e.view = {m_pend, m_gie, m_mask};
      e.req  = m_gie && (win >= 0);
      e.vec  = (win >= 0) ? 16'((5 + win) * 8) : 16'h0;
      e.tag  = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state: view 0x07, no request
      step(0,0,0,5'b00000,3'b000,0,"R1 reset state");
      // R2 enable / disable / both
      step(1,0,0,5'b00000,3'b000,0,"R2 enable");
      step(0,1,0,5'b00000,3'b000,0,"R2 disable");
      step(1,1,0,5'b00000,3'b000,0,"R2 disable wins");
      // R4 write without load-enable, R3 with it
      step(0,0,1,5'b00000,3'b000,0,"R4 masks kept");
      step(0,0,1,5'b01000,3'b000,0,"R3 masks loaded R5");
      step(1,0,0,5'b00000,3'b000,0,"R2 enable again");
      // R6 level source, R8 request, R10 vector 0x28
      step(0,0,0,5'b00000,3'b001,0,"R6 R8 R10 source0");
      step(0,0,0,5'b00000,3'b011,0,"R9 R10 source1 wins");
      step(0,0,0,5'b00000,3'b111,0,"R9 R10 source2 wins");
      // R7 edge source holds after input falls
      step(0,0,0,5'b00000,3'b011,0,"R7 edge held");
      // R11 acknowledge of source 2
      step(0,0,0,5'b00000,3'b011,1,"R11 ack edge source");
      step(1,0,0,5'b00000,3'b011,0,"R9 source1 after re-enable");
      step(0,0,1,5'b01010,3'b011,0,"R3 R9 mask source1");
      step(0,0,0,5'b00000,3'b011,1,"R11 ack level kept");
      step(0,0,0,5'b00000,3'b000,0,"R6 level drops");
      step(0,0,0,5'b00000,3'b100,0,"R8 edge pending no gie");
      step(0,0,0,5'b00000,3'b000,0,"R7 edge held while idle");
      step(0,0,1,5'b10000,3'b000,0,"R7 R4 clear by write");
      step(1,0,0,5'b00000,3'b100,0,"R7 R10 new edge vector");
      step(0,0,1,5'b01100,3'b100,0,"R8 masked edge no req");
      step(0,0,1,5'b01000,3'b100,0,"R8 unmask edge req");
      step(0,0,0,5'b00000,3'b000,1,"R11 ack clears edge");
      step(0,0,0,5'b00000,3'b000,0,"R1 quiet end");
      repeat (2) @(negedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule